// File: doc/BRIEF.md
# Dithered Six-Plus-Two Bit PWM Generator

This block turns an 8-bit duty value into one pulse-width-modulated pin. A free-running 8-bit counter steps once per system clock. One full PWM period is 256 clocks. It is cut into four sub-cycles of 64 clocks each.

The upper six duty bits give a base high time for every sub-cycle. The lower two bits choose how many of the sub-cycles, counted from sub-cycle 0, get one extra high clock. The average duty therefore has 8-bit resolution. The ripple seen by a downstream filter runs at the sub-cycle rate, a quarter of the full period.

The generator drives a pin that it shares with a general port. A direction input decides whether the pin is an output at all, and a port data bit either passes the waveform or holds the pin low. A new duty value takes effect only at the start of a full period.

Top module: `dpwm_gen`

## Requirements
- R1: A synchronous reset (`rst` high) drives `pin_o` and `pin_oe_o` low, clears the counter to 0 and clears the held duty to 0. After reset is released, the first 256 output clocks therefore stay low, whatever `duty_i` holds.
- R2: The held duty splits into two fields. The base count B is duty bits 7..2. The stretch count S is duty bits 1..0.
- R3: Counter bits 7..6 give the sub-cycle index k. In sub-cycle k the high time is B+1 clocks when k < S, and B clocks otherwise.
- R4: Counter bits 5..0 give the position in the sub-cycle. The output is high at positions 0 up to (high time − 1) and low for the rest of the sub-cycle. A high time of 0 keeps the sub-cycle fully low, and a high time of 64 keeps it fully high.
- R5: Over one full 256-clock period, the number of high output clocks equals the held duty value.
- R6: The counter wraps from 255 to 0. Sub-cycles repeat every 64 clocks, and a full period lasts 256 clocks.
- R7: `duty_i` is captured only in the clock where the counter wraps from 255 to 0. A change in the middle of a period has no effect until the next period starts.
- R8: When `pin_dir_i` is 1 (input), `pin_o` is 0 and `pin_oe_o` is 0 on the next clock. When `pin_dir_i` is 0 (output), `pin_oe_o` is 1 on the next clock.
- R9: With `pin_dir_i` at 0, a `port_bit_i` of 0 holds `pin_o` low on the next clock. A `port_bit_i` of 1 lets the waveform through.
- R10: `pin_o` is registered. Its value after a clock edge reflects the counter, held duty, `pin_dir_i` and `port_bit_i` as they were just before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that steps the counter |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | 8 | Requested duty value, captured at the period boundary |
| pin_dir_i | input | 1 | Pin direction: 0 means output, 1 means input |
| port_bit_i | input | 1 | Port data bit: 1 passes the waveform, 0 forces the pin low |
| pin_o | output | 1 | Registered PWM level driven onto the shared pin |
| pin_oe_o | output | 1 | Registered output enable for the shared pin |

## Verification
The counter and the held duty cannot be read directly, so a wrong value in either shows up at the pin. A counter that skips or misorders a state moves the edge positions within the very next sub-cycle, at most 64 clocks later. A held duty that is wrong, or that is captured outside the wrap clock, changes the high count of the current 256-clock period. The bench therefore compares `pin_o` and `pin_oe_o` on every clock against its own count-driven model. It also totals the high clocks and rising edges over whole aligned periods, which catches stretch errors that put one extra clock in the wrong sub-cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int DEF_POS_W = 6;
    localparam int DEF_SUB_W = 2;

    typedef struct packed {
        logic pin;
        logic oe;
    } pin_out_t;

endpackage

// File: rtl/dpwm_counter.sv
module dpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cnt_o  = state_q.cnt;
    assign wrap_o = &state_q.cnt;

endmodule

// File: rtl/dpwm_duty_reg.sv
module dpwm_duty_reg #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic [DUTY_W-1:0] duty_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } duty_state_t;

    duty_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.duty = duty_i;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign duty_o = state_q.duty;

endmodule

// File: rtl/dpwm_wave.sv
module dpwm_wave #(
    parameter int POS_W = 6,
    parameter int SUB_W = 2
) (
    input  logic [POS_W+SUB_W-1:0] cnt_i,
    input  logic [POS_W+SUB_W-1:0] duty_i,
    output logic                   hi_o
);

    localparam int DUTY_W = POS_W + SUB_W;
    localparam int THR_W  = POS_W + 1;

    logic [POS_W-1:0] pos_w;
    logic [POS_W-1:0] base_w;
    logic             stretch_w;
    logic [THR_W-1:0] thr_w;

    assign pos_w  = cnt_i[POS_W-1:0];
    assign base_w = duty_i[DUTY_W-1:SUB_W];

    generate
        if (SUB_W == 0) begin : g_no_dither
            assign stretch_w = 1'b0;
        end else begin : g_dither
            logic [SUB_W-1:0] sub_w;
            logic [SUB_W-1:0] extra_w;
            assign sub_w     = cnt_i[DUTY_W-1:POS_W];
            assign extra_w   = duty_i[SUB_W-1:0];
            assign stretch_w = (sub_w < extra_w);
        end
    endgenerate

    always_comb begin
        thr_w = {1'b0, base_w} + THR_W'(stretch_w);
        hi_o  = ({1'b0, pos_w} < thr_w);
    end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
    import dpwm_pkg::*;
#(
    parameter int POS_W = DEF_POS_W,
    parameter int SUB_W = DEF_SUB_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [POS_W+SUB_W-1:0] duty_i,
    input  logic                   pin_dir_i,
    input  logic                   port_bit_i,
    output logic                   pin_o,
    output logic                   pin_oe_o
);

    localparam int DUTY_W = POS_W + SUB_W;

    logic [DUTY_W-1:0] cnt_w;
    logic [DUTY_W-1:0] duty_w;
    logic              wrap_w;
    logic              wave_hi_w;

    pin_out_t out_d, out_q;

    dpwm_counter #(
        .CNT_W (DUTY_W)
    ) u_counter (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt_w),
        .wrap_o (wrap_w)
    );

    dpwm_duty_reg #(
        .DUTY_W (DUTY_W)
    ) u_duty (
        .clk    (clk),
        .rst    (rst),
        .load_i (wrap_w),
        .duty_i (duty_i),
        .duty_o (duty_w)
    );

    dpwm_wave #(
        .POS_W (POS_W),
        .SUB_W (SUB_W)
    ) u_wave (
        .cnt_i  (cnt_w),
        .duty_i (duty_w),
        .hi_o   (wave_hi_w)
    );

    always_comb begin
        out_d     = out_q;
        out_d.oe  = ~pin_dir_i;
        out_d.pin = wave_hi_w & port_bit_i & ~pin_dir_i;
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign pin_o    = out_q.pin;
    assign pin_oe_o = out_q.oe;

endmodule

// File: rtl/dpwm_gen_chk.sv
module dpwm_gen_chk #(
    parameter int POS_W = 6,
    parameter int SUB_W = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   pin_dir_i,
    input logic                   port_bit_i,
    input logic                   pin_o,
    input logic                   pin_oe_o,
    input logic [POS_W+SUB_W-1:0] cnt_q,
    input logic [POS_W+SUB_W-1:0] duty_q,
    input logic                   wrap,
    input logic                   wave_hi
);

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pin_o && !pin_oe_o));

    assert_prefix_high_R4: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q[POS_W-1:0] != '0) && wave_hi) |-> $past(wave_hi));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));

    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty_q));

    assert_dir_input_R8: assert property (@(posedge clk) disable iff (rst)
        $past(pin_dir_i) |-> (!pin_o && !pin_oe_o));

    assert_dir_output_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(pin_dir_i) && !$past(rst)) |-> pin_oe_o);

    assert_port_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(port_bit_i) |-> !pin_o);

    assert_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(port_bit_i) && !$past(pin_dir_i))
            |-> (pin_o == $past(wave_hi)));

endmodule

bind dpwm_gen dpwm_gen_chk #(
    .POS_W (POS_W),
    .SUB_W (SUB_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pin_dir_i  (pin_dir_i),
    .port_bit_i (port_bit_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .cnt_q      (cnt_w),
    .duty_q     (duty_w),
    .wrap       (wrap_w),
    .wave_hi    (wave_hi_w)
);

// File: tb/dpwm_gen_test.sv
`timescale 1ns/1ps
module dpwm_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty_in = 8'h00;
    logic       dir_in = 1'b0;
    logic       bit_in = 1'b1;
    logic       pin_o;
    logic       pin_oe_o;

    int compared = 0;
    int mism = 0;
    int hi_count = 0;
    int rise_count = 0;
    logic prev_pin = 1'b0;
    bit done = 1'b0;

    int mcnt = 0;
    logic [7:0] mduty = 8'h00;

    typedef struct {
        logic  p;
        logic  oe;
        string tag;
    } exp_t;

    exp_t sb[$];
    exp_t got;

    always #2.5 clk = ~clk;

    dpwm_gen uut (
        .clk        (clk),
        .rst        (rst),
        .duty_i     (duty_in),
        .pin_dir_i  (dir_in),
        .port_bit_i (bit_in),
        .pin_o      (pin_o),
        .pin_oe_o   (pin_oe_o)
    );

    // Driver: predicts the output after the coming edge and waits one clock.
    task automatic step(input string tag);
        exp_t e;
        int   pos, sub, thr;
        if (rst) begin
            e.p = 1'b0; e.oe = 1'b0;
            mcnt = 0; mduty = 8'h00;
        end else begin
            pos = mcnt % 64;
            sub = mcnt / 64;
            thr = int'(mduty[7:2]) + ((sub < int'(mduty[1:0])) ? 1 : 0);
            e.p  = (pos < thr) && bit_in && !dir_in;
            e.oe = !dir_in;
            if (mcnt == 255) mduty = duty_in;
            mcnt = (mcnt + 1) % 256;
        end
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: pops one expectation per edge and compares.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            got = sb.pop_front();
            compared++;
            if (pin_o !== got.p || pin_oe_o !== got.oe) begin
                mism++;
                $display("FAIL %s: pin_o=%b pin_oe_o=%b expected pin_o=%b pin_oe_o=%b",
                         got.tag, pin_o, pin_oe_o, got.p, got.oe);
            end
            if (pin_o === 1'b1) hi_count++;
            if (pin_o === 1'b1 && prev_pin !== 1'b1) rise_count++;
            prev_pin = pin_o;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mism++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic to_boundary(input string tag);
        step(tag);
        while (mcnt != 0) step(tag);
    endtask

    task automatic measure(input logic [7:0] d, input string tag, input int exp_rises);
        duty_in = d; dir_in = 1'b0; bit_in = 1'b1;
        to_boundary(tag);
        hi_count = 0; rise_count = 0;
        repeat (256) step(tag);
        check(hi_count == int'(d), {"R5 high clocks per period, ", tag}, hi_count, int'(d));
        if (exp_rises >= 0)
            check(rise_count == exp_rises, {"R6 rising edges per period, ", tag},
                  rise_count, exp_rises);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            compared++;
            mism++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst = 1'b1;
        repeat (4) step("R1 reset state");
        check(pin_o == 1'b0 && pin_oe_o == 1'b0, "R1 outputs low in reset",
              int'({pin_o, pin_oe_o}), 0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6 R10: patterns over aligned periods
        measure(8'h00, "R2 R4 zero duty", 0);
        measure(8'h40, "R2 R3 base only", 4);
        measure(8'h41, "R3 one stretched sub-cycle", 4);
        measure(8'h83, "R3 three stretched sub-cycles", 4);
        measure(8'h01, "R4 single high clock", 1);
        measure(8'h03, "R3 R4 stretch only", 3);
        measure(8'hFE, "R4 near full", -1);
        measure(8'hFF, "R4 R10 full high", -1);
        measure(8'h80, "R6 ripple period", 4);
        measure(8'h5A, "R10 registered path", 4);

        // R7: mid-period duty change waits for the wrap
        duty_in = 8'h20;
        to_boundary("R7 setup");
        hi_count = 0;
        repeat (100) step("R7 old duty");
        duty_in = 8'hC0;
        repeat (156) step("R7 old duty after change");
        check(hi_count == 32, "R7 period kept old duty", hi_count, 32);
        hi_count = 0;
        repeat (256) step("R7 new duty");
        check(hi_count == 192, "R7 next period uses new duty", hi_count, 192);

        // R8: input direction
        duty_in = 8'h80; dir_in = 1'b1;
        hi_count = 0;
        repeat (256) step("R8 direction input");
        check(hi_count == 0, "R8 pin low while input", hi_count, 0);
        check(pin_oe_o == 1'b0, "R8 enable low while input", int'(pin_oe_o), 0);
        dir_in = 1'b0;
        step("R8 direction back to output");
        check(pin_oe_o == 1'b1, "R8 enable high while output", int'(pin_oe_o), 1);

        // R9: port bit gating
        bit_in = 1'b0;
        hi_count = 0;
        repeat (256) step("R9 port bit low");
        check(hi_count == 0, "R9 pin held low", hi_count, 0);
        duty_in = 8'hA5;
        for (int i = 0; i < 512; i++) begin
            bit_in = ((i / 7) % 2 == 0);
            step("R9 port bit toggling");
        end
        bit_in = 1'b1;

        // R1: reset in mid period clears the held duty
        duty_in = 8'h80;
        repeat (50) step("R1 before mid reset");
        rst = 1'b1;
        repeat (3) step("R1 mid reset");
        rst = 1'b0;
        hi_count = 0;
        repeat (256) step("R1 first period after reset");
        check(hi_count == 0, "R1 cleared duty after reset", hi_count, 0);
        hi_count = 0;
        repeat (256) step("R1 R7 period after first wrap");
        check(hi_count == 128, "R1 R7 duty captured at first wrap", hi_count, 128);

        done = 1'b1;
        report();
        $finish;
    end

endmodule